// File: doc/BRIEF.md
# TSF Timer and Beacon Scheduler

This block keeps the 64-bit microsecond time base of a wireless MAC station. A one-cycle `us_tick` advances the counter. The host drives it through a small write-only register port. Through that port the host can take a snapshot of the counter, add a programmed 64-bit correction to it, and ask for the time of the next beacon. The counter itself is always visible on `tsf_now`.

When a beacon arrives, the receive path presents the beacon's timestamp and its rate index with `bcn_valid`. The block then works out how far the local time has drifted, allowing for a receive latency that depends on the rate. It stores that difference as the correction and applies it one cycle later. A beacon-time request rounds the current count up to the next whole multiple of the beacon period, with the period given in 1024 µs units. A serial divider finds the remainder, and `div_busy` stays high for the whole computation. Once a target is armed, `tbtt_pulse` fires each time the counter reaches it, and the target then moves on by one period.

Top module: `tsf_beacon_timer`

## Requirements
- R1: After reset, `tsf_now`, `snap_val`, `sync_offset` and `tbtt_target` are zero, and `snap_busy`, `div_busy` and `tbtt_pulse` are low.
- R2: On each clock edge that samples `us_tick` high, with no correction applied, the counter grows by exactly one. Otherwise it holds.
- R3: A write to address 0 with bit 0 set raises `snap_busy` after that edge. At the next edge, `snap_val` takes the counter value held before that edge and `snap_busy` clears.
- R4: Writes to addresses 2 and 3 set the low and high 32-bit words of the correction. A write to address 0 with bit 1 set adds the correction to the counter, modulo 2^64, at the following edge. The request clears itself and is applied only once.
- R5: When `bcn_valid` is high and `bcn_ts` differs from the counter, the correction becomes `bcn_ts - (counter + L)`. This is applied at the next edge, so with no ticks the counter becomes `bcn_ts - L`.
- R6: When `bcn_valid` is high and `bcn_ts` equals the counter, neither the correction nor the counter changes.
- R7: The latency L in µs is chosen by `bcn_rate` modulo 12. Indices 0 to 11 map to 17, 17, 17, 17, 34, 23, 17, 11, 8, 5, 4 and 3.
- R8: Address 1 holds the 16-bit beacon period P, in units of 1024 µs. A write to address 0 with bit 2 set captures the counter C. When `div_busy` falls, `tbtt_target` equals (floor(C / (P·1024)) + 1)·P·1024.
- R9: With P equal to zero, the request copies C to `tbtt_target` unchanged and leaves the target disarmed, so no pulse follows.
- R10: With an armed target, `tbtt_pulse` goes high for one cycle at the edge after the counter equals the target. At that same edge the target grows by P·1024.
- R11: A beacon-time request written while `div_busy` is high is ignored. So is a change to P made during that time: the running computation uses the period it captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick | input | 1 | One-microsecond advance strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address: 0 control, 1 period, 2 and 3 correction words, low word first |
| reg_wdata | input | 32 | Register write data |
| bcn_valid | input | 1 | Received beacon timestamp is present |
| bcn_ts | input | 64 | Received beacon timestamp |
| bcn_rate | input | 4 | Rate index of the received beacon |
| tsf_now | output | 64 | Running counter |
| snap_busy | output | 1 | Snapshot requested and not yet valid |
| snap_val | output | 64 | Latched counter snapshot |
| sync_offset | output | 64 | Current correction value |
| div_busy | output | 1 | Beacon-time computation in progress |
| tbtt_target | output | 64 | Next beacon target time |
| tbtt_pulse | output | 1 | Target reached |

## Verification
Four checks run on every cycle. The counter must step by exactly the tick whenever no correction is pending. A snapshot must carry the counter value from the cycle in which it cleared. A pulse may appear only after a cycle in which counter and target were equal. The divider may not stay busy longer than its fixed length. Some behaviour can only be shown by the bench's scenarios, because each needs a reference value: the arithmetic of the beacon correction across all sixteen rate codes, the rounding to the next period boundary for random periods and counts, the zero-period pass-through, and the rule that requests made while the divider runs are dropped.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
   // register map: control, period, then correction words low first
   localparam int unsigned A_CTRL = 0;
   localparam int unsigned A_PER  = 1;
   localparam int unsigned A_OFS0 = 2;
   // control bit positions
   localparam int unsigned C_SNAP = 0;
   localparam int unsigned C_OFS  = 1;
   localparam int unsigned C_TBTT = 2;
endpackage

// File: rtl/tsf_rx_latency.sv
module tsf_rx_latency #(
   parameter int unsigned RATE_W = 4,
   parameter int unsigned LAT_W  = 6
) (
   input  logic [RATE_W-1:0] rate,
   output logic [LAT_W-1:0]  lat_us
);
   localparam int unsigned NRATES = 12;
   logic [RATE_W-1:0] idx;

   initial assert (RATE_W == 4 && LAT_W >= 6)
      else $error("tsf_rx_latency: unsupported widths");

   always_comb begin
      idx = (rate >= RATE_W'(NRATES)) ? rate - RATE_W'(NRATES) : rate;
      unique case (idx)
         4'd4:    lat_us = LAT_W'(34);
         4'd5:    lat_us = LAT_W'(23);
         4'd7:    lat_us = LAT_W'(11);
         4'd8:    lat_us = LAT_W'(8);
         4'd9:    lat_us = LAT_W'(5);
         4'd10:   lat_us = LAT_W'(4);
         4'd11:   lat_us = LAT_W'(3);
         default: lat_us = LAT_W'(17);
      endcase
   end
endmodule

// File: rtl/tsf_rem_div.sv
module tsf_rem_div #(
   parameter int unsigned NUM_W = 64,
   parameter int unsigned DEN_W = 26
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [NUM_W-1:0] num,
   input  logic [DEN_W-1:0] den,
   output logic             busy,
   output logic             done,
   output logic [DEN_W-1:0] rem
);
   localparam int unsigned CW = $clog2(NUM_W + 1);

   logic [DEN_W:0]   acc;
   logic [DEN_W:0]   trial;
   logic [NUM_W-1:0] sh;
   logic [DEN_W-1:0] den_q;
   logic [CW-1:0]    left;

   initial assert (NUM_W > DEN_W && DEN_W > 0)
      else $error("tsf_rem_div: dividend must be wider than divisor");

   assign trial = {acc[DEN_W-1:0], sh[NUM_W-1]};
   assign rem   = acc[DEN_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc   <= '0;
         sh    <= '0;
         den_q <= '0;
         left  <= '0;
         busy  <= 1'b0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start && !busy) begin
            acc   <= '0;
            sh    <= num;
            den_q <= den;
            left  <= CW'(NUM_W);
            busy  <= 1'b1;
         end else if (busy) begin
            acc  <= (trial >= {1'b0, den_q}) ? trial - {1'b0, den_q} : trial;
            sh   <= sh << 1;
            left <= left - 1'b1;
            if (left == CW'(1)) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/tsf_beacon_timer.sv
module tsf_beacon_timer
   import tsf_pkg::*;
#(
   parameter int unsigned CNT_W    = 64,
   parameter int unsigned REG_W    = 32,
   parameter int unsigned ADDR_W   = 3,
   parameter int unsigned PER_W    = 16,
   parameter int unsigned TU_SHIFT = 10,
   parameter int unsigned RATE_W   = 4,
   parameter int unsigned LAT_W    = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              us_tick,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   input  logic              bcn_valid,
   input  logic [CNT_W-1:0]  bcn_ts,
   input  logic [RATE_W-1:0] bcn_rate,
   output logic [CNT_W-1:0]  tsf_now,
   output logic              snap_busy,
   output logic [CNT_W-1:0]  snap_val,
   output logic [CNT_W-1:0]  sync_offset,
   output logic              div_busy,
   output logic [CNT_W-1:0]  tbtt_target,
   output logic              tbtt_pulse
);
   localparam int unsigned NWORDS = CNT_W / REG_W;
   localparam int unsigned DIV_W  = PER_W + TU_SHIFT;

   initial begin
      assert (CNT_W % REG_W == 0) else $error("CNT_W must be a multiple of REG_W");
      assert (A_OFS0 + NWORDS <= (1 << ADDR_W)) else $error("address space too small");
      assert (DIV_W < CNT_W && PER_W <= REG_W) else $error("period too wide");
   end

   logic [CNT_W-1:0]  tsf_q, ofs_q, ofs_next, base_q, per_x;
   logic [PER_W-1:0]  per_q;
   logic [DIV_W-1:0]  period_q, rem;
   logic [LAT_W-1:0]  lat;
   logic [NWORDS-1:0] word_we;
   logic ctrl_wr, ofs_req_q, tbtt_req_q, bcn_apply, armed_q;
   logic dv_busy, dv_done, dv_start;

   assign ctrl_wr   = reg_wr && (reg_addr == ADDR_W'(A_CTRL));
   assign bcn_apply = bcn_valid && (bcn_ts != tsf_q);
   assign div_busy  = tbtt_req_q | dv_busy | dv_done;
   assign dv_start  = tbtt_req_q && (per_q != '0);
   assign per_x     = CNT_W'(period_q);

   tsf_rx_latency #(.RATE_W(RATE_W), .LAT_W(LAT_W)) i_lat (
      .rate   (bcn_rate),
      .lat_us (lat)
   );

   // one write enable per correction word, low word at the lowest address
   for (genvar w = 0; w < NWORDS; w++) begin : g_ofs_we
      assign word_we[w] = reg_wr && (reg_addr == ADDR_W'(A_OFS0 + w));
   end

   always_comb begin
      ofs_next = ofs_q;
      for (int w = 0; w < NWORDS; w++)
         if (word_we[w]) ofs_next[w*REG_W +: REG_W] = reg_wdata;
      if (bcn_apply) ofs_next = bcn_ts - tsf_q - CNT_W'(lat);
   end

   tsf_rem_div #(.NUM_W(CNT_W), .DEN_W(DIV_W)) i_div (
      .clk   (clk),
      .rst_n (rst_n),
      .start (dv_start),
      .num   (tsf_q),
      .den   ({per_q, TU_SHIFT'(0)}),
      .busy  (dv_busy),
      .done  (dv_done),
      .rem   (rem)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tsf_q       <= '0;
         ofs_q       <= '0;
         ofs_req_q   <= 1'b0;
         snap_busy   <= 1'b0;
         snap_val    <= '0;
         per_q       <= '0;
         period_q    <= '0;
         base_q      <= '0;
         tbtt_req_q  <= 1'b0;
         tbtt_target <= '0;
         armed_q     <= 1'b0;
         tbtt_pulse  <= 1'b0;
      end else begin
         tsf_q     <= tsf_q + CNT_W'(us_tick) + (ofs_req_q ? ofs_q : '0);
         ofs_q     <= ofs_next;
         ofs_req_q <= (ctrl_wr && reg_wdata[C_OFS]) || bcn_apply;
         snap_busy <= ctrl_wr && reg_wdata[C_SNAP];
         if (snap_busy) snap_val <= tsf_q;
         if (reg_wr && reg_addr == ADDR_W'(A_PER)) per_q <= reg_wdata[PER_W-1:0];
         tbtt_req_q <= ctrl_wr && reg_wdata[C_TBTT] && !div_busy;
         tbtt_pulse <= 1'b0;
         if (tbtt_req_q) begin
            base_q   <= tsf_q;
            period_q <= {per_q, TU_SHIFT'(0)};
            if (per_q == '0) begin
               tbtt_target <= tsf_q;
               armed_q     <= 1'b0;
            end
         end else if (dv_done) begin
            tbtt_target <= base_q - CNT_W'(rem) + per_x;
            armed_q     <= 1'b1;
         end else if (armed_q && tsf_q == tbtt_target) begin
            tbtt_target <= tbtt_target + per_x;
            tbtt_pulse  <= 1'b1;
         end
      end
   end

   assign tsf_now     = tsf_q;
   assign sync_offset = ofs_q;
endmodule

module tsf_beacon_timer_chk #(
   parameter int unsigned CNT_W = 64
) (
   input logic             clk,
   input logic             rst_n,
   input logic             us_tick,
   input logic             ofs_apply,
   input logic [CNT_W-1:0] tsf_now,
   input logic             snap_busy,
   input logic [CNT_W-1:0] snap_val,
   input logic             div_busy,
   input logic [CNT_W-1:0] tbtt_target,
   input logic             tbtt_pulse
);
   localparam int unsigned RUN_W = $clog2(CNT_W + 8) + 1;
   logic [RUN_W-1:0] run;

   always_ff @(posedge clk) begin
      if (!rst_n) run <= '0;
      else        run <= div_busy ? run + 1'b1 : '0;
   end

   // R2
   tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ofs_apply |=> tsf_now == $past(tsf_now) + CNT_W'($past(us_tick)));
   // R3
   snap_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(snap_busy) |-> snap_val == $past(tsf_now));
   // R10
   pulse_at_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tbtt_pulse |-> $past(tsf_now) == $past(tbtt_target));
   // R8
   div_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
      div_busy |-> run < RUN_W'(CNT_W + 2));
endmodule

bind tsf_beacon_timer tsf_beacon_timer_chk #(.CNT_W(CNT_W)) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .us_tick     (us_tick),
   .ofs_apply   (ofs_req_q),
   .tsf_now     (tsf_now),
   .snap_busy   (snap_busy),
   .snap_val    (snap_val),
   .div_busy    (div_busy),
   .tbtt_target (tbtt_target),
   .tbtt_pulse  (tbtt_pulse)
);

// File: tb/test_tsf_beacon_timer.sv
module test_tsf_beacon_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        us_tick = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic        bcn_valid = 1'b0;
   logic [63:0] bcn_ts = '0;
   logic [3:0]  bcn_rate = '0;
   logic [63:0] tsf_now, snap_val, sync_offset, tbtt_target;
   logic        snap_busy, div_busy, tbtt_pulse;

   int n_chk = 0;
   int n_bad = 0;
   bit done_flag = 0;

   always #4 clk = ~clk;

   tsf_beacon_timer i_tsf_beacon_timer (
      .clk, .rst_n, .us_tick, .reg_wr, .reg_addr, .reg_wdata,
      .bcn_valid, .bcn_ts, .bcn_rate, .tsf_now, .snap_busy, .snap_val,
      .sync_offset, .div_busy, .tbtt_target, .tbtt_pulse
   );

   function automatic logic [63:0] lat_of(input logic [3:0] r);
      int unsigned t[12] = '{17, 17, 17, 17, 34, 23, 17, 11, 8, 5, 4, 3};
      return 64'(t[r % 12]);
   endfunction

   function automatic logic [63:0] next_bcn(input logic [63:0] c, input logic [15:0] p);
      logic [63:0] d;
      d = 64'(p) * 64'd1024;
      if (d == 0) return c;
      return (c / d + 1) * d;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      if (!done_flag) begin
         done_flag = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   // correction write and apply; tick must be low
   task automatic set_cnt(input logic [63:0] v, input bit check);
      logic [63:0] o;
      o = v - tsf_now;
      wr(3'd2, o[31:0]);
      wr(3'd3, o[63:32]);
      wr(3'd0, 32'h2);
      @(negedge clk);
      if (check) chk(tsf_now == v, "R4 correction applied", tsf_now, v);
   endtask

   task automatic beacon(input logic [63:0] ts, input logic [3:0] r);
      logic [63:0] c0, e;
      c0 = tsf_now;
      bcn_ts = ts; bcn_rate = r; bcn_valid = 1'b1;
      @(negedge clk);
      bcn_valid = 1'b0;
      e = ts - c0 - lat_of(r);
      chk(sync_offset == e, "R5 R7 beacon correction", sync_offset, e);
      @(negedge clk);
      chk(tsf_now == ts - lat_of(r), "R5 counter after beacon", tsf_now, ts - lat_of(r));
   endtask

   task automatic wait_div();
      for (int k = 0; k < 200 && div_busy; k++) @(negedge clk);
   endtask

   task automatic tbtt(input logic [15:0] p);
      logic [63:0] c0, e;
      wr(3'd1, 32'(p));
      c0 = tsf_now;
      wr(3'd0, 32'h4);
      wait_div();
      e = next_bcn(c0, p);
      chk(!div_busy && tbtt_target == e, (p == 0) ? "R9 zero period" : "R8 next target", tbtt_target, e);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
   end

   initial begin
      logic [63:0] c0, t, o0;
      int ones, seen;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk(tsf_now == 0 && snap_val == 0 && sync_offset == 0 && tbtt_target == 0, "R1 reset values", tsf_now, 0);
      chk({snap_busy, div_busy, tbtt_pulse} == 3'b000, "R1 reset flags", 64'({snap_busy, div_busy, tbtt_pulse}), 0);

      // R2 random tick pattern
      for (int it = 0; it < 4; it++) begin
         c0 = tsf_now; ones = 0;
         for (int i = 0; i < 40; i++) begin
            us_tick = 1'($urandom);
            ones += int'(us_tick);
            @(negedge clk);
         end
         us_tick = 1'b0;
         chk(tsf_now == c0 + 64'(ones), "R2 tick count", tsf_now, c0 + 64'(ones));
      end

      // R4 correction with wrap, then self-clear
      set_cnt(64'hFFFF_FFFF_FFFF_FFF0, 1'b1);
      set_cnt(64'h0000_0000_0000_0005, 1'b1);
      c0 = tsf_now;
      repeat (3) @(negedge clk);
      chk(tsf_now == c0, "R4 single apply", tsf_now, c0);

      // R3 snapshot under random ticks
      for (int it = 0; it < 4; it++) begin
         set_cnt({$urandom, $urandom}, 1'b0);
         us_tick = 1'($urandom);
         wr(3'd0, 32'h1);
         chk(snap_busy == 1'b1, "R3 busy raised", 64'(snap_busy), 1);
         c0 = tsf_now;
         @(negedge clk);
         us_tick = 1'b0;
         chk(!snap_busy && snap_val == c0, "R3 snapshot value", snap_val, c0);
      end

      // R5 R7 beacon correction for every rate code
      for (int r = 0; r < 16; r++) begin
         set_cnt({$urandom, $urandom}, 1'b0);
         beacon({$urandom, $urandom}, 4'(r));
      end

      // R6 equal timestamps
      set_cnt(64'h1234_5678_9ABC, 1'b0);
      o0 = sync_offset; c0 = tsf_now;
      bcn_ts = c0; bcn_rate = 4'd4; bcn_valid = 1'b1;
      @(negedge clk);
      bcn_valid = 1'b0;
      repeat (2) @(negedge clk);
      chk(sync_offset == o0 && tsf_now == c0, "R6 equal timestamp ignored", tsf_now, c0);

      // R8 directed corners and random periods
      set_cnt(64'd0, 1'b0);
      tbtt(16'd1);
      set_cnt(64'd1023, 1'b0);
      tbtt(16'd1);
      set_cnt(64'd1024, 1'b0);
      tbtt(16'd1);
      set_cnt(64'hFFFF_FFFF_FFFF_0000, 1'b0);
      tbtt(16'hFFFF);
      for (int it = 0; it < 8; it++) begin
         set_cnt({16'h0, $urandom, 16'($urandom)}, 1'b0);
         tbtt(16'($urandom | 1));
      end

      // R10 pulse and advance
      set_cnt(64'd5000, 1'b0);
      tbtt(16'd3);
      t = tbtt_target;
      set_cnt(t - 64'd3, 1'b0);
      us_tick = 1'b1;
      seen = 0;
      for (int k = 0; k < 20 && !tbtt_pulse; k++) begin
         @(negedge clk);
         seen++;
      end
      chk(tbtt_pulse && seen == 4, "R10 pulse timing", 64'(seen), 4);
      chk(tsf_now == t + 1 && tbtt_target == t + 64'd3072, "R10 target advance", tbtt_target, t + 64'd3072);
      @(negedge clk);
      us_tick = 1'b0;
      chk(!tbtt_pulse, "R10 single pulse", 64'(tbtt_pulse), 0);

      // R9 zero period: no pulse although counter equals target
      tbtt(16'd0);
      seen = 0;
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         seen += int'(tbtt_pulse);
      end
      chk(seen == 0, "R9 disarmed", 64'(seen), 0);

      // R11 request and period change during computation
      set_cnt(64'd777_777, 1'b0);
      c0 = tsf_now;
      wr(3'd1, 32'd7);
      wr(3'd0, 32'h4);
      wr(3'd1, 32'd2);
      wr(3'd0, 32'h4);
      wait_div();
      chk(tbtt_target == next_bcn(c0, 16'd7), "R11 busy request ignored", tbtt_target, next_bcn(c0, 16'd7));
      repeat (3) @(negedge clk);
      chk(!div_busy, "R11 no second run", 64'(div_busy), 0);

      summary();
   end
endmodule